// File: doc/BRIEF.md
# Windowed Channel Extractor for Pixel Packets

This block takes a stream of fixed-length packets. Each packet opens with a frame index byte and then carries `FRAME_SIZE` channel bytes, so packet `f` holds the global channels `f*FRAME_SIZE` to `f*FRAME_SIZE + FRAME_SIZE - 1`. Two configuration inputs choose a window of channels: the first global channel of interest and the number of channels. The block keeps only the bytes inside that window and writes each one into a pixel RAM. Channel `cfg_start` goes to address 0. Packets whose frame holds no part of the window are thrown away whole.

The trimming is worked out per packet. In the frame that holds the window's first channel, copying begins partway into the payload. In the frame that holds the window's last channel, copying stops early. Every frame between them is copied whole. Once the packet carrying the window's final frame has been written out, a one-cycle trigger tells the downstream LED encoder that the buffer is ready to stream.

Reception is double buffered. A new packet fills one bank while the copy engine drains the other, and the two banks trade roles in the cycle a good packet completes. If an accepted packet completes while the engine is still busy, that packet is dropped and an overrun pulse is raised. The bank in use is left untouched.

Top module: `frame_chan_extract`

## Requirements
- R1: While `rst_n` is low at a clock edge, `pix_we`, `start_pulse` and `overrun` are all 0 after that edge.
- R2: A packet is one `in_valid` beat with `in_sop`=1 whose low `FR_W` bits of `in_data` give the frame index, followed by exactly `FRAME_SIZE` data beats, with `in_eop`=1 on the last beat. A packet that is shorter or longer than this is dropped with no write, overrun or trigger. So are beats that arrive outside a packet, and a beat with both `in_sop` and `in_eop` set.
- R3: A well-formed packet with frame `f` is accepted only when `cfg_count` is nonzero and `cfg_start/FRAME_SIZE <= f <= (cfg_start+cfg_count-1)/FRAME_SIZE`. Any other packet produces no write.
- R4: For an accepted packet, each payload byte at position `k` (0-based) whose global channel `c = f*FRAME_SIZE + k` satisfies `cfg_start <= c < cfg_start+cfg_count` is written once, with its byte, to `pix_addr = c - cfg_start`. The writes go in ascending address order on consecutive cycles, and no other bytes are written.
- R5: Every write has `pix_addr < cfg_count`.
- R6: `start_pulse` is high for exactly one cycle. It rises only in the cycle right after the final write of a packet whose frame equals `(cfg_start+cfg_count-1)/FRAME_SIZE`, and it is low while `pix_we` is high.
- R7: A packet can be received while the previous packet is still being copied. If an accepted packet completes while the copy engine is busy, `overrun` pulses for one cycle, that packet is dropped, and the packet being copied is written unchanged.
- R8: `pix_we` first rises on the second clock edge after the edge that samples an accepted packet's `in_eop` beat. One packet's copy therefore finishes within `FRAME_SIZE + 2` cycles of that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_start | input | CH_W | First global channel of the window |
| cfg_count | input | CH_W | Number of channels in the window |
| in_valid | input | 1 | Input beat valid |
| in_sop | input | 1 | Beat is the frame index byte opening a packet |
| in_eop | input | 1 | Beat is the last byte of a packet |
| in_data | input | DATA_W | Beat payload |
| pix_we | output | 1 | Pixel RAM write enable |
| pix_addr | output | CH_W | Pixel RAM write address |
| pix_data | output | DATA_W | Pixel RAM write data |
| start_pulse | output | 1 | One-cycle trigger after the window's last frame is written |
| overrun | output | 1 | One-cycle pulse when a completed packet is dropped because the engine is busy |

## Verification
The main sweep tries every window start from 0 to 15 against window lengths from 1 to 12, with four-channel frames. This covers windows held in one frame, windows that straddle a frame boundary, and windows that span several frames. Each case separates the start-trim, stop-trim and whole-frame copy paths, and each shows whether frames outside the range are rejected. A zero-length window checks that nothing is accepted. Short, long and stray beats check that packet framing is enforced. Two back-to-back pairs tell the two reception cases apart: a packet that arrives during a one-byte copy must succeed, while one that completes during a full-frame copy must be flagged as an overrun without corrupting the bank being drained.

// File: rtl/fce_pkg.sv
// Package: shared width helpers for the frame channel extractor.
// Assumes callers pass positive sizes.
package fce_pkg;

    // Index width for an array of n entries (at least one bit).
    function automatic int fce_idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Width of a counter that must hold the value n itself.
    function automatic int fce_cnt_w(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/fce_window.sv
// Module: fce_window
// Purely combinational window arithmetic for one frame index.
// It yields the accept decision, the payload span [lo, hi) to copy and the
// pixel address of the first copied byte. Assumes cfg_count > 0 for any
// accept; a zero count rejects every frame.
module fce_window #(
    parameter int FRAME_SIZE = 8,
    parameter int CH_W       = 9,
    parameter int FR_W       = 8,
    parameter int OFF_W      = 4
) (
    input  logic [CH_W-1:0]  cfg_start,
    input  logic [CH_W-1:0]  cfg_count,
    input  logic [FR_W-1:0]  frame,
    output logic             in_range,
    output logic             is_last,
    output logic [OFF_W-1:0] lo,
    output logic [OFF_W-1:0] hi,
    output logic [CH_W-1:0]  base
);
    localparam int WW = CH_W + FR_W + OFF_W + 1;

    logic [WW-1:0] s_w, e_w, first_w, last_w, f_w, fbase_w, lo_w, hi_w, base_w;

    // Derive frame bounds, trims and base address from the channel window.
    always_comb begin
        s_w      = WW'(cfg_start);
        e_w      = s_w + WW'(cfg_count);
        first_w  = s_w / WW'(FRAME_SIZE);
        last_w   = (e_w - WW'(1)) / WW'(FRAME_SIZE);
        f_w      = WW'(frame);
        fbase_w  = f_w * WW'(FRAME_SIZE);
        in_range = (cfg_count != '0) && (f_w >= first_w) && (f_w <= last_w);
        is_last  = (f_w == last_w);
        lo_w     = (f_w == first_w) ? (s_w - fbase_w) : '0;
        hi_w     = is_last ? (e_w - fbase_w) : WW'(FRAME_SIZE);
        base_w   = fbase_w + lo_w - s_w;
        lo       = OFF_W'(lo_w);
        hi       = OFF_W'(hi_w);
        base     = CH_W'(base_w);
    end
endmodule

// File: rtl/fce_rx.sv
// Module: fce_rx
// Packet receiver with two payload banks. It checks the framing, stores the
// frame index and payload in the write bank, and on a good, accepted packet
// either hands the bank to the copy engine (swapping banks) or flags an overrun
// if the engine is busy. Assumes acc_ok reflects cur_frame combinationally.
module fce_rx #(
    parameter int FRAME_SIZE = 8,
    parameter int FR_W       = 8,
    parameter int DATA_W     = 8,
    parameter int OFF_W      = 4,
    parameter int IDX_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [DATA_W-1:0] in_data,
    input  logic              acc_ok,
    input  logic              eng_busy,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [FR_W-1:0]   cur_frame,
    output logic [FR_W-1:0]   rd_frame,
    output logic [DATA_W-1:0] rd_byte,
    output logic              launch,
    output logic              overrun
);
    logic [DATA_W-1:0] bank_mem [2][FRAME_SIZE];
    logic [FR_W-1:0]   bank_frm [2];
    logic              wr_sel, rd_sel, active;
    logic [OFF_W-1:0]  cnt;
    logic              data_beat, good_end;

    // Classify the current beat.
    always_comb begin
        data_beat = in_valid && !in_sop && active;
        good_end  = data_beat && in_eop && (cnt == OFF_W'(FRAME_SIZE - 1));
    end

    // Framing state, bank selection, handoff and overrun pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_sel  <= 1'b0;
            rd_sel  <= 1'b0;
            active  <= 1'b0;
            cnt     <= '0;
            launch  <= 1'b0;
            overrun <= 1'b0;
        end else begin
            launch  <= 1'b0;
            overrun <= 1'b0;
            if (in_valid && in_sop) begin
                cnt    <= '0;
                active <= !in_eop;
            end else if (data_beat) begin
                cnt <= cnt + OFF_W'(1);
                if (in_eop || cnt == OFF_W'(FRAME_SIZE - 1)) begin
                    active <= 1'b0;
                end
                if (good_end && acc_ok) begin
                    if (eng_busy) begin
                        overrun <= 1'b1;
                    end else begin
                        launch <= 1'b1;
                        rd_sel <= wr_sel;
                        wr_sel <= ~wr_sel;
                    end
                end
            end
        end
    end

    // Bank storage: frame index on the opening beat, payload on data beats.
    always_ff @(posedge clk) begin
        if (in_valid && in_sop) begin
            bank_frm[wr_sel] <= in_data[FR_W-1:0];
        end
        if (data_beat && cnt < OFF_W'(FRAME_SIZE)) begin
            bank_mem[wr_sel][cnt[IDX_W-1:0]] <= in_data;
        end
    end

    // Read side for the window logic and the copy engine.
    always_comb begin
        cur_frame = bank_frm[wr_sel];
        rd_frame  = bank_frm[rd_sel];
        rd_byte   = bank_mem[rd_sel][rd_idx];
    end
endmodule

// File: rtl/fce_copy.sv
// Module: fce_copy
// Copy engine. On launch it latches the span and the base address, then emits
// one registered pixel write per cycle and raises a one-cycle trigger after
// the final write of the window's last frame. Assumes lo < hi at launch.
module fce_copy #(
    parameter int CH_W   = 9,
    parameter int DATA_W = 8,
    parameter int OFF_W  = 4,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [OFF_W-1:0]  lo,
    input  logic [OFF_W-1:0]  hi,
    input  logic [CH_W-1:0]   base,
    input  logic              is_last,
    input  logic [DATA_W-1:0] rd_byte,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              busy,
    output logic              pix_we,
    output logic [CH_W-1:0]   pix_addr,
    output logic [DATA_W-1:0] pix_data,
    output logic              start_pulse
);
    logic [OFF_W-1:0] idx, hi_q;
    logic [CH_W-1:0]  addr;
    logic             last_q, fin_q;

    // Walk the span, issue writes and generate the trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy        <= 1'b0;
            idx         <= '0;
            hi_q        <= '0;
            addr        <= '0;
            last_q      <= 1'b0;
            fin_q       <= 1'b0;
            pix_we      <= 1'b0;
            pix_addr    <= '0;
            pix_data    <= '0;
            start_pulse <= 1'b0;
        end else begin
            pix_we      <= 1'b0;
            fin_q       <= 1'b0;
            start_pulse <= pix_we && fin_q;
            if (launch) begin
                busy   <= 1'b1;
                idx    <= lo;
                hi_q   <= hi;
                addr   <= base;
                last_q <= is_last;
            end else if (busy) begin
                pix_we   <= 1'b1;
                pix_addr <= addr;
                pix_data <= rd_byte;
                addr     <= addr + CH_W'(1);
                idx      <= idx + OFF_W'(1);
                if (idx == hi_q - OFF_W'(1)) begin
                    busy  <= 1'b0;
                    fin_q <= last_q;
                end
            end
        end
    end

    // Payload read index into the engine's bank.
    always_comb rd_idx = idx[IDX_W-1:0];
endmodule

// File: rtl/frame_chan_extract.sv
// Module: frame_chan_extract (top)
// Extracts a configured channel window from fixed-size frame packets into a
// pixel RAM and triggers the LED encoder after the window's last frame.
// Assumes cfg_start/cfg_count are held stable while packets are in flight
// and that FR_W <= DATA_W.
module frame_chan_extract #(
    parameter int FRAME_SIZE = 8,
    parameter int CH_W       = 9,
    parameter int FR_W       = 8,
    parameter int DATA_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CH_W-1:0]   cfg_start,
    input  logic [CH_W-1:0]   cfg_count,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [DATA_W-1:0] in_data,
    output logic              pix_we,
    output logic [CH_W-1:0]   pix_addr,
    output logic [DATA_W-1:0] pix_data,
    output logic              start_pulse,
    output logic              overrun
);
    localparam int OFF_W = fce_pkg::fce_cnt_w(FRAME_SIZE);
    localparam int IDX_W = fce_pkg::fce_idx_w(FRAME_SIZE);

    logic [FR_W-1:0]   cur_frame, rd_frame, win_frame;
    logic [DATA_W-1:0] rd_byte;
    logic [IDX_W-1:0]  rd_idx;
    logic              launch, eng_busy, in_range, is_last;
    logic [OFF_W-1:0]  lo, hi;
    logic [CH_W-1:0]   base;

    // One window calculator, shared: the end-of-packet check and the engine
    // latch never happen in the same cycle.
    always_comb win_frame = launch ? rd_frame : cur_frame;

    fce_window #(.FRAME_SIZE(FRAME_SIZE), .CH_W(CH_W), .FR_W(FR_W), .OFF_W(OFF_W)) win_i (
        .cfg_start (cfg_start),
        .cfg_count (cfg_count),
        .frame     (win_frame),
        .in_range  (in_range),
        .is_last   (is_last),
        .lo        (lo),
        .hi        (hi),
        .base      (base)
    );

    fce_rx #(.FRAME_SIZE(FRAME_SIZE), .FR_W(FR_W), .DATA_W(DATA_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) rx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sop    (in_sop),
        .in_eop    (in_eop),
        .in_data   (in_data),
        .acc_ok    (in_range),
        .eng_busy  (eng_busy),
        .rd_idx    (rd_idx),
        .cur_frame (cur_frame),
        .rd_frame  (rd_frame),
        .rd_byte   (rd_byte),
        .launch    (launch),
        .overrun   (overrun)
    );

    fce_copy #(.CH_W(CH_W), .DATA_W(DATA_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) copy_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch      (launch),
        .lo          (lo),
        .hi          (hi),
        .base        (base),
        .is_last     (is_last),
        .rd_byte     (rd_byte),
        .rd_idx      (rd_idx),
        .busy        (eng_busy),
        .pix_we      (pix_we),
        .pix_addr    (pix_addr),
        .pix_data    (pix_data),
        .start_pulse (start_pulse)
    );
endmodule

// File: rtl/fce_checker.sv
// Module: fce_checker
// Temporal properties on the extractor's ports, attached by bind below.
// Assumes the configuration is stable while writes are in progress.
module fce_checker #(
    parameter int CH_W = 9
) (
    input logic            clk,
    input logic            rst_n,
    input logic [CH_W-1:0] cfg_count,
    input logic            pix_we,
    input logic [CH_W-1:0] pix_addr,
    input logic            start_pulse,
    input logic            overrun
);
    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (!pix_we && !start_pulse && !overrun)); // R1
    AST_ADDR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n) pix_we |-> (pix_addr < cfg_count)); // R5
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n) (pix_we && $past(pix_we)) |-> ((pix_addr - $past(pix_addr)) == CH_W'(1))); // R4
    AST_TRIG_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n) start_pulse |-> ($past(pix_we) && !pix_we)); // R6
    AST_TRIG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) start_pulse |=> !start_pulse); // R6
    AST_OVERRUN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) overrun |=> !overrun); // R7
endmodule

bind frame_chan_extract fce_checker #(.CH_W(CH_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_count   (cfg_count),
    .pix_we      (pix_we),
    .pix_addr    (pix_addr),
    .start_pulse (start_pulse),
    .overrun     (overrun)
);

// File: tb/frame_chan_extract_tb_top.sv
module frame_chan_extract_tb_top;
    localparam int FS  = 4;
    localparam int CW  = 5;
    localparam int FW  = 4;
    localparam int NCH = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] cfg_start = '0, cfg_count = '0;
    logic          in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [7:0]    in_data = '0;
    logic          pix_we, start_pulse, overrun;
    logic [CW-1:0] pix_addr;
    logic [7:0]    pix_data;

    int tests = 0, fails = 0, cyc = 0;
    int hits [NCH];
    int wr_total = 0, trig_cnt = 0, ovr_cnt = 0, last_eop_cyc = -100;
    int cur_start = 0, cur_count = 0, cur_salt = 0;
    bit prev_we = 1'b0, finished = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    frame_chan_extract #(.FRAME_SIZE(FS), .CH_W(CW), .FR_W(FW), .DATA_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_count(cfg_count),
        .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop), .in_data(in_data),
        .pix_we(pix_we), .pix_addr(pix_addr), .pix_data(pix_data),
        .start_pulse(start_pulse), .overrun(overrun)
    );

    function automatic logic [7:0] pat(input int c, input int salt);
        return 8'((c * 37 + salt * 11 + 5) & 255);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Port monitor, sampling away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (pix_we) begin
                if (!prev_we) chk(cyc == last_eop_cyc + 3, "R8 first write latency", cyc, last_eop_cyc + 3);
                if (int'(pix_addr) >= cur_count) begin
                    chk(1'b0, "R5 address outside window", int'(pix_addr), cur_count);
                end else begin
                    chk(pix_data == pat(int'(pix_addr) + cur_start, cur_salt), "R4 write data",
                        int'(pix_data), int'(pat(int'(pix_addr) + cur_start, cur_salt)));
                    hits[pix_addr]++;
                end
                wr_total++;
            end
            if (start_pulse) begin
                trig_cnt++;
                chk(prev_we && !pix_we, "R6 trigger follows final write", int'(prev_we), 1);
                chk(wr_total == cur_count, "R6 all window bytes written before trigger", wr_total, cur_count);
            end
            if (overrun) ovr_cnt++;
        end
        prev_we = pix_we;
    end

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        end
    endtask

    task automatic send_pkt(input int frame, input int salt, input int nbytes, input int gap);
        for (int k = 0; k <= nbytes; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sop   = (k == 0);
            in_eop   = (k == nbytes);
            in_data  = (k == 0) ? 8'(frame) : pat(frame * FS + k - 1, salt);
            if (k == nbytes) last_eop_cyc = cyc;
        end
        if (gap > 0) idle(gap);
    endtask

    task automatic setup(input int s, input int c, input int salt);
        @(negedge clk);
        cfg_start = CW'(s); cfg_count = CW'(c);
        cur_start = s; cur_count = c; cur_salt = salt;
        for (int i = 0; i < NCH; i++) hits[i] = 0;
        wr_total = 0; trig_cnt = 0; ovr_cnt = 0;
    endtask

    task automatic verify(input string tag, input int exp_ovr);
        int bad = 0;
        idle(12);
        for (int a = 0; a < NCH; a++) if (hits[a] != ((a < cur_count) ? 1 : 0)) bad++;
        chk(bad == 0, {tag, " R4 each window address written once"}, bad, 0);
        chk(wr_total == cur_count, {tag, " R3 only in-range frames written"}, wr_total, cur_count);
        chk(trig_cnt == ((cur_count > 0) ? 1 : 0), {tag, " R6 trigger count"}, trig_cnt, (cur_count > 0) ? 1 : 0);
        chk(ovr_cnt == exp_ovr, {tag, " R7 overrun count"}, ovr_cnt, exp_ovr);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!pix_we && !start_pulse && !overrun, "R1 outputs quiet in reset",
            int'({pix_we, start_pulse, overrun}), 0);
        rst_n = 1'b1;
        idle(2);
        chk(!pix_we && !start_pulse && !overrun, "R1 outputs quiet after reset",
            int'({pix_we, start_pulse, overrun}), 0);

        // R3 R4 R6 R8: sweep windows over every start and length, frames 0..7 in order.
        for (int s = 0; s < 16; s++) begin
            for (int c = 1; c <= 12; c++) begin
                setup(s, c, s * 13 + c);
                for (int f = 0; f < 8; f++) send_pkt(f, s * 13 + c, FS, 3);
                verify("sweep", 0);
            end
        end

        // R3: an empty window accepts nothing.
        setup(5, 0, 7);
        for (int f = 0; f < 8; f++) send_pkt(f, 7, FS, 3);
        verify("empty window", 0);

        // R2: short, long, stray and single-beat packets are dropped; framing then recovers.
        setup(2, 10, 21);
        send_pkt(1, 21, FS - 1, 3);
        send_pkt(1, 21, FS + 1, 3);
        @(negedge clk); in_valid = 1'b1; in_sop = 1'b0; in_eop = 1'b1; in_data = 8'h01;
        @(negedge clk); in_valid = 1'b1; in_sop = 1'b1; in_eop = 1'b1; in_data = 8'h00;
        idle(12);
        chk(wr_total == 0 && trig_cnt == 0 && ovr_cnt == 0, "R2 malformed packets ignored", wr_total + trig_cnt + ovr_cnt, 0);
        for (int f = 0; f < 3; f++) send_pkt(f, 21, FS, 3);
        verify("R2 recovery", 0);

        // R7: back-to-back packet received during a one-byte copy is kept.
        setup(3, 9, 33);
        send_pkt(0, 33, FS, 0);
        send_pkt(1, 33, FS, 3);
        send_pkt(2, 33, FS, 3);
        verify("R7 overlap ok", 0);

        // R7: packet completing during a full-frame copy overruns and is dropped.
        setup(0, 12, 44);
        send_pkt(0, 44, FS, 0);
        send_pkt(1, 44, FS, 3);
        idle(10);
        chk(ovr_cnt == 1 && wr_total == FS, "R7 dropped packet made no writes", wr_total, FS);
        send_pkt(1, 44, FS, 3);
        send_pkt(2, 44, FS, 3);
        verify("R7 overrun", 1);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule